// File: doc/BRIEF.md
# Bus-Side Wait-For-Interrupt Stall Unit

This block sits next to an 8-bit microprocessor that has no native wait-for-interrupt instruction and gives it one from outside the core. It watches the opcode-fetch strobe and the data bus. When the processor fetches a chosen single-cycle undefined opcode, the default being 0xCB, the block pulls the processor's ready line low. The processor stays frozen until either interrupt request line goes active.

The stall decision is combinational within the fetch cycle, because the processor samples ready at the end of the phase-2 half-cycle while the opcode is still on the bus. A wait flag is registered on the phase-2 clock edge. It keeps the stall in place for as long as both interrupt lines stay inactive, and it clears on the first edge where either line is low. An optional external ready request is ANDed into the output. The wait adds no setup cycles beyond the trapped fetch itself. If the processor has interrupts enabled, it takes the interrupt only after the first normal instruction that follows the trap.

All pins are plain control and status levels. None of them carries a data stream, so there is no valid/ready handshake and no back-pressure rule. The ready output is the only way the block holds the processor back.

Top module: `wfi_stall_unit`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and on leaving it with no trap on the bus, the wait flag is clear and `rdy_o` equals `ext_rdy_i`.
- R2: In a cycle with `sync_i` high, `dbus_i` equal to 0xCB and both `irq_n_i` and `nmi_n_i` high, `rdy_o` is low in that same cycle, with no clock edge in between.
- R3: A 0xCB byte seen while `sync_i` is low does not stall, either in that cycle or in later cycles.
- R4: An opcode other than 0xCB fetched with `sync_i` high does not stall.
- R5: After a trap has been seen at a clock edge, `rdy_o` stays low while both interrupt lines stay high, whatever `sync_i` and `dbus_i` do.
- R6: `irq_n_i` low releases the stall in the same cycle. The wait flag clears at that edge, so `rdy_o` stays high afterwards unless a new trap is fetched.
- R7: `nmi_n_i` low releases the stall and clears the wait flag in the same way as `irq_n_i`.
- R8: A trap fetched while either interrupt line is already low neither stalls nor sets the wait flag.
- R9: `rdy_o` is `ext_rdy_i` AND NOT stall. A low `ext_rdy_i` forces `rdy_o` low, and a wait flag set while `ext_rdy_i` was low still holds once `ext_rdy_i` returns high.
- R10: Asserting reset during a wait clears the wait flag and releases `rdy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_phi2 | input | 1 | Phase-2 processor clock; the wait flag updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | High during an opcode-fetch cycle |
| dbus_i | input | 8 | Processor data bus |
| irq_n_i | input | 1 | Maskable interrupt request, active low |
| nmi_n_i | input | 1 | Non-maskable interrupt request, active low |
| ext_rdy_i | input | 1 | External ready request, high means ready |
| rdy_o | output | 1 | Combined ready line to the processor |

## Verification
Directed patterns place the trap byte in a fetch cycle and in an operand cycle, and place a different opcode in a fetch cycle. Together these separate decoding of the fetch strobe from decoding of the byte. Each interrupt line is raised on its own, during a wait and also before a trap. This shows that release and clear are separate from the set path, and that either line alone is enough. Further cases drive the external ready low and assert reset mid-wait to isolate the AND merge and the reset release. A seeded random stream with bias toward the trap byte and toward quiet interrupt lines then checks every cycle against a bench model of the flag.

// File: rtl/wfi_pkg.sv
package wfi_pkg;
  localparam int unsigned BUS_W        = 8;
  localparam logic [7:0]  TRAP_DEFAULT = 8'hCB;
  localparam logic [7:0]  MASK_DEFAULT = 8'hFF;

  // True when any active-low interrupt request is asserted.
  function automatic logic int_pending(input logic irq_n, input logic nmi_n);
    return (~irq_n) | (~nmi_n);
  endfunction
endpackage

// File: rtl/wfi_opcode_match.sv
module wfi_opcode_match #(
  parameter int unsigned          W      = 8,
  parameter logic [W-1:0]         OPCODE = 8'hCB,
  parameter logic [W-1:0]         MASK   = 8'hFF
) (
  input  logic         sync_i,
  input  logic [W-1:0] bus_i,
  output logic         hit_o
);
  logic [W-1:0] bit_ok;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MASK[b]) begin : g_cmp
      assign bit_ok[b] = (bus_i[b] == OPCODE[b]);
    end else begin : g_dc
      assign bit_ok[b] = 1'b1;
    end
  end

  assign hit_o = sync_i & (&bit_ok);
endmodule

// File: rtl/wfi_wait_reg.sv
module wfi_wait_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic int_pend_i,
  output logic wait_o,
  output logic stall_o
);
  logic wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wait_q <= 1'b0;
    else if (int_pend_i) wait_q <= 1'b0;
    else if (hit_i)      wait_q <= 1'b1;
  end

  assign wait_o  = wait_q;
  assign stall_o = (hit_i | wait_q) & ~int_pend_i;
endmodule

// File: rtl/wfi_rdy_merge.sv
module wfi_rdy_merge (
  input  logic rst_n,
  input  logic ext_rdy_i,
  input  logic stall_i,
  output logic rdy_o
);
  always_comb begin
    if (!rst_n) rdy_o = ext_rdy_i;
    else        rdy_o = ext_rdy_i & ~stall_i;
  end
endmodule

// File: rtl/wfi_stall_unit.sv
module wfi_stall_unit
  import wfi_pkg::*;
#(
  parameter int unsigned      BUS_WIDTH = BUS_W,
  parameter logic [BUS_W-1:0] TRAP_OP   = TRAP_DEFAULT,
  parameter logic [BUS_W-1:0] TRAP_MASK = MASK_DEFAULT
) (
  input  logic                 clk_phi2,
  input  logic                 rst_n,
  input  logic                 sync_i,
  input  logic [BUS_WIDTH-1:0] dbus_i,
  input  logic                 irq_n_i,
  input  logic                 nmi_n_i,
  input  logic                 ext_rdy_i,
  output logic                 rdy_o
);
  logic trap_hit;
  logic int_pend;
  logic wait_flag;
  logic stall;

  assign int_pend = int_pending(irq_n_i, nmi_n_i);

  wfi_opcode_match #(
    .W      (BUS_WIDTH),
    .OPCODE (TRAP_OP[BUS_WIDTH-1:0]),
    .MASK   (TRAP_MASK[BUS_WIDTH-1:0])
  ) u_match (
    .sync_i (sync_i),
    .bus_i  (dbus_i),
    .hit_o  (trap_hit)
  );

  wfi_wait_reg u_wait (
    .clk        (clk_phi2),
    .rst_n      (rst_n),
    .hit_i      (trap_hit),
    .int_pend_i (int_pend),
    .wait_o     (wait_flag),
    .stall_o    (stall)
  );

  wfi_rdy_merge u_merge (
    .rst_n     (rst_n),
    .ext_rdy_i (ext_rdy_i),
    .stall_i   (stall),
    .rdy_o     (rdy_o)
  );
endmodule

// File: rtl/wfi_stall_unit_chk.sv
module wfi_stall_unit_chk #(
  parameter int unsigned      BW   = 8,
  parameter logic [BW-1:0]    TRAP = 8'hCB
) (
  input logic          clk_phi2,
  input logic          rst_n,
  input logic          sync_i,
  input logic [BW-1:0] dbus_i,
  input logic          irq_n_i,
  input logic          nmi_n_i,
  input logic          ext_rdy_i,
  input logic          rdy_o
);
  // R2: trap fetch with quiet interrupts stalls in the same cycle
  a_r2_trap_stalls: assert property (@(posedge clk_phi2) disable iff (!rst_n)
    (sync_i && dbus_i == TRAP && irq_n_i && nmi_n_i) |-> !rdy_o);

  // R5: stall with external ready high persists while interrupts stay quiet
  a_r5_wait_holds: assert property (@(posedge clk_phi2) disable iff (!rst_n)
    (ext_rdy_i && !rdy_o && irq_n_i && nmi_n_i) ##1 (irq_n_i && nmi_n_i) |-> !rdy_o);

  // R6: active IRQ line means no stall
  a_r6_irq_releases: assert property (@(posedge clk_phi2) disable iff (!rst_n)
    !irq_n_i |-> (rdy_o == ext_rdy_i));

  // R7: active NMI line means no stall
  a_r7_nmi_releases: assert property (@(posedge clk_phi2) disable iff (!rst_n)
    !nmi_n_i |-> (rdy_o == ext_rdy_i));

  // R6/R7: flag cleared after an interrupt cycle
  a_r6_flag_cleared: assert property (@(posedge clk_phi2) disable iff (!rst_n)
    (!irq_n_i || !nmi_n_i) ##1 (!(sync_i && dbus_i == TRAP)) |-> (rdy_o == ext_rdy_i));

  // R9: external ready low always forces the output low
  a_r9_ext_gates: assert property (@(posedge clk_phi2) disable iff (!rst_n)
    !ext_rdy_i |-> !rdy_o);
endmodule

bind wfi_stall_unit wfi_stall_unit_chk #(.BW(BUS_WIDTH), .TRAP(TRAP_OP)) u_chk (
  .clk_phi2  (clk_phi2),
  .rst_n     (rst_n),
  .sync_i    (sync_i),
  .dbus_i    (dbus_i),
  .irq_n_i   (irq_n_i),
  .nmi_n_i   (nmi_n_i),
  .ext_rdy_i (ext_rdy_i),
  .rdy_o     (rdy_o)
);

// File: tb/wfi_stall_unit_tb_top.sv
`timescale 1ns/1ps
module wfi_stall_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic [7:0] dbus = 8'h00;
  logic       irq_n = 1'b1;
  logic       nmi_n = 1'b1;
  logic       ext_rdy = 1'b1;
  logic       rdy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic m_wait = 1'b0;

  always #10 clk = ~clk;

  wfi_stall_unit dut_i (
    .clk_phi2 (clk), .rst_n (rst_n), .sync_i (sync), .dbus_i (dbus),
    .irq_n_i (irq_n), .nmi_n_i (nmi_n), .ext_rdy_i (ext_rdy), .rdy_o (rdy)
  );

  function automatic logic f_hit(logic s, logic [7:0] d);
    return s && (d == 8'hCB);
  endfunction

  function automatic logic f_rdy(logic r, logic s, logic [7:0] d, logic i, logic n, logic e, logic w);
    if (!r) return e;
    return e && !((f_hit(s, d) || w) && i && n);
  endfunction

  function automatic logic f_next(logic r, logic s, logic [7:0] d, logic i, logic n, logic w);
    if (!r) return 1'b0;
    if (!i || !n) return 1'b0;
    if (f_hit(s, d)) return 1'b1;
    return w;
  endfunction

  task automatic step(input logic r, input logic s, input logic [7:0] d,
                      input logic i, input logic n, input logic e, input string req);
    logic exp;
    @(negedge clk);
    rst_n = r; sync = s; dbus = d; irq_n = i; nmi_n = n; ext_rdy = e;
    #5;
    exp = f_rdy(r, s, d, i, n, e, m_wait);
    checks++;
    if (rdy !== exp) begin
      errors++;
      $display("FAIL %s: rdy_o=%b expected=%b (sync=%b bus=%h irq_n=%b nmi_n=%b ext=%b)",
               req, rdy, exp, s, d, i, n, e);
    end
    @(posedge clk);
    m_wait = f_next(r, s, d, i, n, m_wait);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset holds output at external ready even with a trap on the bus
    step(0, 1, 8'hCB, 1, 1, 1, "R1");
    step(0, 0, 8'h00, 1, 1, 0, "R1");
    step(1, 0, 8'h00, 1, 1, 1, "R1");
    // R4: other opcode in a fetch
    step(1, 1, 8'hEA, 1, 1, 1, "R4");
    step(1, 1, 8'hCA, 1, 1, 1, "R4");
    // R3: trap byte outside a fetch
    step(1, 0, 8'hCB, 1, 1, 1, "R3");
    step(1, 0, 8'h00, 1, 1, 1, "R3");
    // R2 and R5: trap, then hold
    step(1, 1, 8'hCB, 1, 1, 1, "R2");
    step(1, 1, 8'hCB, 1, 1, 1, "R5");
    step(1, 0, 8'h12, 1, 1, 1, "R5");
    // R6: IRQ release and clear
    step(1, 1, 8'hCB, 0, 1, 1, "R6");
    step(1, 0, 8'h12, 1, 1, 1, "R6");
    // R7: NMI release and clear
    step(1, 1, 8'hCB, 1, 1, 1, "R2");
    step(1, 1, 8'hCB, 1, 0, 1, "R7");
    step(1, 1, 8'hEA, 1, 1, 1, "R7");
    // R8: trap while an interrupt is already pending
    step(1, 1, 8'hCB, 0, 1, 1, "R8");
    step(1, 0, 8'h00, 1, 1, 1, "R8");
    step(1, 1, 8'hCB, 1, 0, 1, "R8");
    step(1, 1, 8'hEA, 1, 1, 1, "R8");
    // R9: external ready merge
    step(1, 0, 8'h00, 1, 1, 0, "R9");
    step(1, 1, 8'hCB, 1, 1, 0, "R9");
    step(1, 0, 8'h00, 1, 1, 1, "R9");
    step(1, 0, 8'h00, 1, 0, 1, "R9");
    step(1, 0, 8'h00, 1, 1, 1, "R9");
    // R10: reset during a wait
    step(1, 1, 8'hCB, 1, 1, 1, "R2");
    step(0, 0, 8'h00, 1, 1, 1, "R10");
    step(1, 0, 8'h00, 1, 1, 1, "R10");
    // Random stream: biased toward trap byte and quiet interrupts (R5 mix)
    for (int k = 0; k < 600; k++) begin
      logic s, i, n, e;
      logic [7:0] d;
      s = ($urandom % 2) == 0;
      d = (($urandom % 3) == 0) ? 8'hCB : 8'($urandom);
      i = ($urandom % 6) != 0;
      n = ($urandom % 8) != 0;
      e = ($urandom % 5) != 0;
      step(1, s, d, i, n, e, "R5");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule